// File: doc/BRIEF.md
# Signed Binary to Packed Decimal Store Converter

This block sits at the tail of a floating-point store path. It takes a signed 64-bit integer that an upstream stage has already rounded from the top-of-stack value. It turns that integer into an 80-bit packed-decimal word. The result is presented as a 64-bit low part and a 16-bit high part, ready for a memory stage to write. A one-cycle `start` strobe launches a conversion. A one-cycle `done` pulse marks the cycle in which the result and its `invalid_out` flag are first valid. The result stays on the ports until the next accepted launch.

The sign is taken off first and kept apart. Only the magnitude is turned into digits, by a shift-and-add-three loop that handles one binary bit per cycle. The result can hold at most eighteen decimal digits. An operand whose magnitude is too large gives a fixed "indefinite" pattern instead of digits, and so does an operand that arrives with the upstream invalid flag already set. The most negative 64-bit value falls into this out-of-range case.

The controller has three states. `ST_IDLE` waits for `start`. The transition `IDLE->FINISH` is taken for a rejected operand, and `IDLE->CONVERT` for an accepted one. `ST_CONVERT` runs 60 shift steps and then takes `CONVERT->FINISH`. `ST_FINISH` raises `done` and always returns through `FINISH->IDLE`.

Top module: `bcd_store_conv`

## Requirements
- R1: After reset `done`, `invalid_out`, `res_lo` and `res_hi` are all zero.
- R2: A valid result holds the magnitude's decimal digits least significant first: digits 0 to 15 sit in `res_lo` nibbles 0 to 15 (digit k at bits 4k+3:4k), digit 16 in `res_hi[3:0]` and digit 17 in `res_hi[7:4]`; every nibble is 0 to 9.
- R3: In a valid result `res_hi[15]` is 1 for a negative operand and 0 otherwise, and `res_hi[14:8]` is zero.
- R4: An operand whose magnitude exceeds 999999999999999999 sets `invalid_out` and yields `res_hi` = 0xFFFF and `res_lo` = 0xC000000000000000.
- R5: When `in_invalid` is 1 at the launch, the same indefinite result and `invalid_out` = 1 are produced, whatever the operand.
- R6: The operand -2^63 is treated as out of range and yields the indefinite result.
- R7: For an accepted operand, `done` is high for exactly one cycle, 61 clock edges after the edge that samples `start`.
- R8: For a rejected operand, `done` is high for exactly one cycle, on the edge right after the edge that samples `start`.
- R9: `start` is ignored while a conversion is running or while `done` is high.
- R10: `res_lo`, `res_hi` and `invalid_out` change only in the cycle `done` rises, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, sampled in the idle state only |
| in_value | input | 64 | Signed two's-complement operand |
| in_invalid | input | 1 | Upstream invalid-operation flag |
| res_lo | output | 64 | Low 16 decimal digits of the result |
| res_hi | output | 16 | Sign, padding and top two digits of the result |
| invalid_out | output | 1 | Invalid-operation flag of the held result |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can meet in one cycle. A fresh `start` can land on a cycle where the block is still converting, or on the exact cycle `done` is high. The bench provokes both: it pulses `start` mid-conversion, and it waits for the model's done cycle to pulse `start` again. A rejected launch is also placed right after a completion, so that a one-cycle rejection meets the idle state it needs. The reference model takes `start` only when it counts itself idle, and it is compared against the outputs on every clock. If the design took a launch it should have dropped, its next `done` would come early and its result would change, and the model would show the mismatch. The second meeting is a launch with `in_invalid` set and an out-of-range operand at once. This is judged by the result: a single indefinite pattern arriving on the short latency.

// File: rtl/bcd_store_pkg.sv
package bcd_store_pkg;

    localparam int IN_W      = 64;
    localparam int DIGITS    = 18;
    localparam int LO_DIGITS = 16;
    localparam int MAG_BITS  = 60;
    localparam int HI_W      = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_FINISH
    } conv_state_t;

    // Largest magnitude representable with the given number of decimal digits.
    function automatic logic [IN_W-1:0] max_magnitude(input int digits);
        logic [IN_W-1:0] p;
        p = 1;
        for (int i = 0; i < digits; i++) begin
            p = p * 10;
        end
        return p - 1;
    endfunction

endpackage

// File: rtl/bcd_range_check.sv
module bcd_range_check
    import bcd_store_pkg::*;
#(
    parameter int W      = IN_W,
    parameter int NDIG   = DIGITS,
    parameter int MBITS  = MAG_BITS
) (
    input  logic [W-1:0]     value,
    input  logic             invalid_in,
    output logic [MBITS-1:0] magnitude,
    output logic             negative,
    output logic             reject
);

    localparam logic [W-1:0] LIMIT = max_magnitude(NDIG);

    logic [W-1:0] abs_val;

    always_comb begin
        negative  = value[W-1];
        abs_val   = negative ? (~value + {{(W-1){1'b0}}, 1'b1}) : value;
        // The most negative value negates to itself and therefore exceeds LIMIT.
        reject    = invalid_in || (abs_val > LIMIT);
        magnitude = abs_val[MBITS-1:0];
    end

endmodule

// File: rtl/bcd_dabble_step.sv
module bcd_dabble_step
    import bcd_store_pkg::*;
#(
    parameter int NDIG = DIGITS
) (
    input  logic [4*NDIG-1:0] bcd_in,
    input  logic              bit_in,
    output logic [4*NDIG-1:0] bcd_out
);

    localparam int BW = 4 * NDIG;

    logic [BW-1:0] adjusted;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        always_comb begin
            if (bcd_in[4*g +: 4] >= 4'd5) begin
                adjusted[4*g +: 4] = bcd_in[4*g +: 4] + 4'd3;
            end else begin
                adjusted[4*g +: 4] = bcd_in[4*g +: 4];
            end
        end
    end

    assign bcd_out = {adjusted[BW-2:0], bit_in};

endmodule

// File: rtl/bcd_store_conv.sv
module bcd_store_conv
    import bcd_store_pkg::*;
#(
    parameter int W     = IN_W,
    parameter int NDIG  = DIGITS,
    parameter int LODIG = LO_DIGITS,
    parameter int MBITS = MAG_BITS,
    parameter int HW    = HI_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  in_value,
    input  logic          in_invalid,
    output logic [W-1:0]  res_lo,
    output logic [HW-1:0] res_hi,
    output logic          invalid_out,
    output logic          done
);

    localparam int BW       = 4 * NDIG;
    localparam int LO_BITS  = 4 * LODIG;
    localparam int TOP_BITS = BW - LO_BITS;
    localparam int PAD_BITS = HW - 1 - TOP_BITS;
    localparam int CNT_W    = $clog2(MBITS + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MBITS - 1);
    localparam logic [HW-1:0]    INDEF_HI  = '1;
    localparam logic [W-1:0]     INDEF_LO  = {2'b11, {(W-2){1'b0}}};

    conv_state_t state_q, state_d;

    logic [MBITS-1:0] mag_q;
    logic [BW-1:0]    bcd_q;
    logic [BW-1:0]    bcd_step;
    logic [CNT_W-1:0] cnt_q;
    logic             sign_q;

    logic [MBITS-1:0] chk_mag;
    logic             chk_neg;
    logic             chk_reject;

    bcd_range_check #(.W(W), .NDIG(NDIG), .MBITS(MBITS)) u_range (
        .value      (in_value),
        .invalid_in (in_invalid),
        .magnitude  (chk_mag),
        .negative   (chk_neg),
        .reject     (chk_reject)
    );

    bcd_dabble_step #(.NDIG(NDIG)) u_step (
        .bcd_in  (bcd_q),
        .bit_in  (mag_q[MBITS-1]),
        .bcd_out (bcd_step)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = chk_reject ? ST_FINISH : ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (cnt_q == LAST_STEP) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        done = (state_q == ST_FINISH);
    end

    // Datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q       <= '0;
            bcd_q       <= '0;
            cnt_q       <= '0;
            sign_q      <= 1'b0;
            res_lo      <= '0;
            res_hi      <= '0;
            invalid_out <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (chk_reject) begin
                            res_lo      <= INDEF_LO;
                            res_hi      <= INDEF_HI;
                            invalid_out <= 1'b1;
                        end else begin
                            mag_q  <= chk_mag;
                            bcd_q  <= '0;
                            cnt_q  <= '0;
                            sign_q <= chk_neg;
                        end
                    end
                end
                ST_CONVERT: begin
                    mag_q <= {mag_q[MBITS-2:0], 1'b0};
                    bcd_q <= bcd_step;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) begin
                        res_lo      <= bcd_step[LO_BITS-1:0];
                        res_hi      <= {sign_q, {PAD_BITS{1'b0}}, bcd_step[BW-1:LO_BITS]};
                        invalid_out <= 1'b0;
                    end
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- assertions ----------------

    // R7, R8: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: a rejected result carries the indefinite pattern
    a_r4_indefinite: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid_out) |-> (res_hi == INDEF_HI && res_lo == INDEF_LO));

    // R3: padding bits between sign and top digits are clear in valid results
    a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !invalid_out) |-> (res_hi[HW-2:TOP_BITS] == '0));

    // R10: result ports hold outside the completion cycle
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_lo) && $stable(res_hi) && $stable(invalid_out)));

    // R8: a rejected launch finishes on the next edge with the flag set
    a_r8_reject_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && chk_reject) |=> (done && invalid_out));

    // R7, R9: conversion advances one step per cycle regardless of start
    a_r9_busy_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && cnt_q != LAST_STEP) |=>
            (state_q == ST_CONVERT && cnt_q == $past(cnt_q) + 1'b1));

    // R2: every working digit stays decimal during conversion
    for (genvar d = 0; d < NDIG; d++) begin : g_digit_chk
        a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_CONVERT) |-> (bcd_q[4*d +: 4] <= 4'd9));
    end

endmodule

// File: tb/bcd_store_conv_bench.sv
module bcd_store_conv_bench;

    localparam int VALID_LAT = 61;
    localparam logic [63:0] LIMIT = 64'd999999999999999999;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [63:0] in_value;
    logic        in_invalid;
    logic [63:0] res_lo;
    logic [15:0] res_hi;
    logic        invalid_out;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    bcd_store_conv u_bcd_store_conv (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .in_value    (in_value),
        .in_invalid  (in_invalid),
        .res_lo      (res_lo),
        .res_hi      (res_hi),
        .invalid_out (invalid_out),
        .done        (done)
    );

    // ---------------- reference model ----------------
    int          rem = 0;
    bit          started = 1'b0;
    bit          pend_bad;
    logic [63:0] p_lo, exp_lo;
    logic [15:0] p_hi, exp_hi;
    logic        exp_inv;
    string       cur_tag = "R1";

    function automatic void ref_convert(input logic [63:0] v, input logic inv,
                                        output logic [63:0] lo, output logic [15:0] hi,
                                        output logic bad);
        logic [63:0] m;
        m   = v[63] ? (~v + 64'd1) : v;
        bad = inv || (m > LIMIT);
        if (bad) begin
            lo = 64'hC000_0000_0000_0000;
            hi = 16'hFFFF;
        end else begin
            lo = '0;
            hi = '0;
            for (int i = 0; i < 16; i++) begin
                lo[4*i +: 4] = 4'(m % 10);
                m = m / 10;
            end
            hi[3:0] = 4'(m % 10);
            m = m / 10;
            hi[7:4] = 4'(m % 10);
            hi[15]  = v[63];
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0; exp_lo = '0; exp_hi = '0; exp_inv = 1'b0;
        end else if (rem > 0) begin
            rem = rem - 1;
            if (rem == 1) begin
                exp_lo = p_lo; exp_hi = p_hi; exp_inv = pend_bad;
            end
        end else if (start) begin
            ref_convert(in_value, in_invalid, p_lo, p_hi, pend_bad);
            started = 1'b1;
            if (pend_bad) begin
                rem = 1;
                exp_lo = p_lo; exp_hi = p_hi; exp_inv = 1'b1;
            end else begin
                rem = VALID_LAT;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            string dtag, rtag;
            dtag = !started ? "R1" : (pend_bad ? "R8" : "R7");
            rtag = !started ? "R1" : ((rem == 0) ? "R10" : cur_tag);
            check(dtag, "done", 64'(done), 64'(rem == 1));
            check(rtag, "res_lo", res_lo, exp_lo);
            check(rtag, "res_hi", 64'(res_hi), 64'(exp_hi));
            check(rtag, "invalid_out", 64'(invalid_out), 64'(exp_inv));
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse(input logic [63:0] v, input logic inv);
        @(negedge clk);
        start = 1'b1; in_value = v; in_invalid = inv;
        @(negedge clk);
        start = 1'b0; in_value = '0; in_invalid = 1'b0;
    endtask

    task automatic wait_idle();
        while (rem != 0) @(negedge clk);
    endtask

    task automatic run(input logic [63:0] v, input logic inv, input string tag);
        cur_tag = tag;
        pulse(v, inv);
        wait_idle();
        repeat (2) @(negedge clk);
    endtask

    logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    initial begin
        rst_n = 1'b0; start = 1'b0; in_value = '0; in_invalid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);   // R1: reset values compared each cycle

        run(64'd0, 1'b0, "R2");
        run(64'd7, 1'b0, "R2");
        run(64'd123456789, 1'b0, "R2");
        run(64'd1234567890123456, 1'b0, "R2");
        run(64'd12345678901234567, 1'b0, "R2");
        run(LIMIT, 1'b0, "R2");
        run(-64'sd5, 1'b0, "R3");
        run(-64'sd999999999999999999, 1'b0, "R3");
        run(-64'sd80000000000000001, 1'b0, "R3");
        run(LIMIT + 64'd1, 1'b0, "R4");
        run(64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R4");
        run(-64'sd1000000000000000000, 1'b0, "R4");
        run(64'd42, 1'b1, "R5");
        run(64'h8000_0000_0000_0000, 1'b0, "R6");
        run(64'h8000_0000_0000_0000, 1'b1, "R5");

        // R9: launch during conversion is ignored
        cur_tag = "R9";
        pulse(64'd55555, 1'b0);
        repeat (10) @(negedge clk);
        pulse(64'd999, 1'b1);
        repeat (20) @(negedge clk);
        pulse(-64'sd31, 1'b0);
        // R9: launch on the completion cycle is ignored
        while (rem != 1) @(negedge clk);
        start = 1'b1; in_value = 64'd777; in_invalid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        // R8: rejected launch right after completion
        cur_tag = "R8";
        pulse(LIMIT + 64'd5, 1'b0);
        wait_idle();
        // back-to-back valid launch immediately after idle
        cur_tag = "R7";
        pulse(64'd86420, 1'b0);
        wait_idle();
        repeat (3) @(negedge clk);

        for (int k = 0; k < 24; k++) begin
            logic [63:0] v;
            rs = next_rand(rs);
            v  = rs % (LIMIT + 64'd1);
            if (k % 4 == 1) v = v % 64'd100000;
            if (k % 3 == 0) v = ~v + 64'd1;
            run(v, 1'b0, v[63] ? "R3" : "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule